// File: doc/BRIEF.md
# Cache Invalidate and Freeze Controller

This block is the control half of a small direct-mapped cache. The cache can be organised as one unified store, as an instruction-only store or as an operand-only store. A single control word arrives over a simple write port. The block decodes that word, holds the freeze setting and, when asked, clears the valid bits of the selected sets one per cycle through the valid-bit array port. It also decides for each cache miss whether the line may be refilled.

In the unified organisation the lower half of the sets holds instructions and the upper half holds operands. An invalidate can be limited to either half, and the half that was not chosen is left untouched. While the freeze setting is on, a miss that lands on a valid line is granted without a refill, so no valid line is ever replaced. A miss that lands on an invalid line is still refilled. While a sweep runs, the busy flag is high and the block grants no miss and accepts no new control word, so each invalidate completes before any further access is served.

Top module: `cache_inv_ctrl`

## Requirements
- R1: After reset, busy is low, the valid array is not written and freeze is off, so a granted miss on a valid line refills it.
- R2: A control write with bit 24 set, accepted while idle, raises busy from the next cycle for exactly one cycle per swept set. In each of those cycles one set is cleared (valid write with data 0), in ascending set order.
- R3: In the unified organisation (bits [1:0] = 00 or 11), bit 21 set with bit 20 clear sweeps only sets 0 to SETS/2-1. Upper sets keep their valid bits.
- R4: In the unified organisation, bit 20 set with bit 21 clear sweeps only sets SETS/2 to SETS-1. Lower sets keep their valid bits.
- R5: The whole cache is swept when neither scope bit is set, when both are set, or when the organisation is instruction-only (01) or operand-only (10), whatever the scope bits hold.
- R6: While busy, no miss is granted and any control write is ignored. The ignored write neither starts a further sweep nor changes freeze.
- R7: While idle, a miss request is granted in the same cycle. With freeze off, the grant refills the line by writing valid = 1 to the missed set.
- R8: Freeze is bit 31 of the control word. With freeze on, a miss on a valid set is granted without a refill, and a miss on an invalid set is refilled.
- R9: A write that sets both freeze and invalidate clears the valid bits as usual, and freeze stays on after the sweep ends.
- R10: The invalidate request self-clears. After a sweep, busy stays low until the next write with bit 24, and a write without bit 24 starts no sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: [31] freeze, [24] invalidate, [21] instruction scope, [20] data scope, [1:0] organisation |
| miss_req | input | 1 | Miss allocation request |
| miss_set | input | IDX_W | Set index of the miss |
| va_rdata | input | 1 | Valid bit read from the array at va_addr |
| busy | output | 1 | Sweep in progress; lookups stall |
| miss_gnt | output | 1 | Miss request accepted this cycle |
| miss_fill | output | 1 | Granted miss may refill its line |
| va_addr | output | IDX_W | Valid array set address |
| va_we | output | 1 | Valid array write enable |
| va_wdata | output | 1 | Valid bit to write |

## Verification
Every cycle, the assertions check that a sweep cycle writes a cleared valid bit and moves up by exactly one set, and that nothing is granted while busy. They also check that no refill lands on a valid set under freeze and that an accepted invalidate raises busy. Only the directed scenarios can show which sets a given scope and organisation reach and that the other half keeps its contents. The same applies to a write ignored during a sweep leaving freeze alone, and to freeze surviving an invalidate that carries it.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int FRZ_BIT = 31;
  localparam int INV_BIT = 24;
  localparam int ISC_BIT = 21;
  localparam int DSC_BIT = 20;

  typedef enum logic [1:0] {
    ORG_UNIFIED = 2'b00,
    ORG_INSTR   = 2'b01,
    ORG_DATA    = 2'b10,
    ORG_RSVD    = 2'b11
  } org_e;

  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sweep_st_e;
endpackage

// File: rtl/cic_ctrl_reg.sv
module cic_ctrl_reg
  import cic_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic             busy,
  output logic             frozen,
  output logic             inv_start,
  output logic [IDX_W-1:0] inv_lo,
  output logic [IDX_W-1:0] inv_hi
);
  localparam int HALF = SETS / 2;
  localparam logic [IDX_W-1:0] LAST_SET  = IDX_W'(SETS - 1);
  localparam logic [IDX_W-1:0] LOW_TOP   = IDX_W'(HALF - 1);
  localparam logic [IDX_W-1:0] HIGH_BASE = IDX_W'(HALF);

  logic accept;
  logic frz_d, frz_q;
  org_e org;
  logic split_org;

  always_comb begin
    accept    = cfg_we && !busy;
    org       = org_e'(cfg_wdata[1:0]);
    split_org = (org == ORG_UNIFIED) || (org == ORG_RSVD);
    inv_start = accept && cfg_wdata[INV_BIT];
    inv_lo    = '0;
    inv_hi    = LAST_SET;
    if (split_org && cfg_wdata[ISC_BIT] && !cfg_wdata[DSC_BIT]) begin
      inv_lo = '0;
      inv_hi = LOW_TOP;
    end else if (split_org && cfg_wdata[DSC_BIT] && !cfg_wdata[ISC_BIT]) begin
      inv_lo = HIGH_BASE;
      inv_hi = LAST_SET;
    end
  end

  always_comb begin
    frz_d = frz_q;
    if (accept) frz_d = cfg_wdata[FRZ_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_q <= 1'b0;
    else        frz_q <= frz_d;
  end

  assign frozen = frz_q;
endmodule

// File: rtl/cic_sweep.sv
module cic_sweep
  import cic_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] lo,
  input  logic [IDX_W-1:0] hi,
  output logic             active,
  output logic [IDX_W-1:0] idx
);
  sweep_st_e st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] end_q, end_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    end_d = end_q;
    case (st_q)
      SW_IDLE: begin
        if (start) begin
          st_d  = SW_RUN;
          idx_d = lo;
          end_d = hi;
        end
      end
      SW_RUN: begin
        if (idx_q == end_q) st_d  = SW_IDLE;
        else                idx_d = idx_q + 1'b1;
      end
      default: st_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SW_IDLE;
      idx_q <= '0;
      end_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      end_q <= end_d;
    end
  end

  assign active = (st_q == SW_RUN);
  assign idx    = idx_q;
endmodule

// File: rtl/cic_alloc.sv
module cic_alloc (
  input  logic miss_req,
  input  logic busy,
  input  logic frozen,
  input  logic line_valid,
  output logic gnt,
  output logic fill
);
  always_comb begin
    gnt  = miss_req && !busy;
    fill = gnt && !(frozen && line_valid);
  end
endmodule

// File: rtl/cache_inv_ctrl.sv
module cache_inv_ctrl #(
  parameter int SETS  = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic             miss_req,
  input  logic [IDX_W-1:0] miss_set,
  input  logic             va_rdata,
  output logic             busy,
  output logic             miss_gnt,
  output logic             miss_fill,
  output logic [IDX_W-1:0] va_addr,
  output logic             va_we,
  output logic             va_wdata
);
  logic             frozen;
  logic             inv_start;
  logic [IDX_W-1:0] inv_lo, inv_hi;
  logic [IDX_W-1:0] sweep_idx;

  cic_ctrl_reg #(.SETS(SETS), .IDX_W(IDX_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .busy(busy), .frozen(frozen), .inv_start(inv_start),
    .inv_lo(inv_lo), .inv_hi(inv_hi)
  );

  cic_sweep #(.SETS(SETS), .IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(inv_start), .lo(inv_lo), .hi(inv_hi),
    .active(busy), .idx(sweep_idx)
  );

  cic_alloc u_alloc (
    .miss_req(miss_req), .busy(busy), .frozen(frozen),
    .line_valid(va_rdata), .gnt(miss_gnt), .fill(miss_fill)
  );

  always_comb begin
    va_addr  = busy ? sweep_idx : miss_set;
    va_we    = busy || miss_fill;
    va_wdata = !busy;
  end
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [31:0]      cfg_wdata,
  input logic             busy,
  input logic             miss_gnt,
  input logic             miss_fill,
  input logic [IDX_W-1:0] va_addr,
  input logic             va_we,
  input logic             va_wdata,
  input logic             va_rdata,
  input logic             frozen
);
  AST_SWEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (va_we && !va_wdata)) else $error("sweep cycle without clear"); // R2

  AST_SWEEP_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (va_addr == IDX_W'($past(va_addr) + 1'b1)))
    else $error("sweep skipped a set"); // R2

  AST_INV_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[24] && !busy) |=> busy)
    else $error("invalidate did not start"); // R2

  AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !miss_gnt) else $error("grant during sweep"); // R6

  AST_FILL_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fill |-> miss_gnt) else $error("fill without grant"); // R7

  AST_FREEZE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !busy && va_rdata) |-> !va_we)
    else $error("valid line replaced under freeze"); // R8
endmodule

bind cache_inv_ctrl cic_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .busy(busy), .miss_gnt(miss_gnt), .miss_fill(miss_fill),
  .va_addr(va_addr), .va_we(va_we), .va_wdata(va_wdata),
  .va_rdata(va_rdata), .frozen(frozen)
);

// File: tb/test_cache_inv_ctrl.sv
module test_cache_inv_ctrl;
  localparam int SETS  = 16;
  localparam int IDX_W = $clog2(SETS);
  localparam int HALF  = SETS / 2;
  localparam logic [31:0] W_INV = 32'h0100_0000;
  localparam logic [31:0] W_ISC = 32'h0020_0000;
  localparam logic [31:0] W_DSC = 32'h0010_0000;
  localparam logic [31:0] W_FRZ = 32'h8000_0000;

  logic clk, rst_n, cfg_we, miss_req, va_rdata;
  logic [31:0] cfg_wdata;
  logic [IDX_W-1:0] miss_set, va_addr;
  logic busy, miss_gnt, miss_fill, va_we, va_wdata;

  logic vmem [SETS];
  int   clr_cnt [SETS];
  int   n_chk, n_err;
  bit   done;

  cache_inv_ctrl #(.SETS(SETS)) i_cache_inv_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .miss_req(miss_req), .miss_set(miss_set), .va_rdata(va_rdata),
    .busy(busy), .miss_gnt(miss_gnt), .miss_fill(miss_fill),
    .va_addr(va_addr), .va_we(va_we), .va_wdata(va_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign va_rdata = vmem[va_addr];

  always @(posedge clk) begin
    if (va_we) begin
      vmem[va_addr] <= va_wdata;
      if (!va_wdata) clr_cnt[va_addr] <= clr_cnt[va_addr] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic preset(input logic v);
    for (int i = 0; i < SETS; i++) begin
      vmem[i]    = v;
      clr_cnt[i] = 0;
    end
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic count_busy(output int cnt);
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic miss(input int set, input bit eg, input bit ef, input string req);
    @(negedge clk);
    miss_req = 1'b1; miss_set = IDX_W'(set);
    #1;
    chk(miss_gnt == eg, {req, " grant"}, miss_gnt, eg);
    chk(miss_fill == ef, {req, " fill"}, miss_fill, ef);
    @(negedge clk);
    miss_req = 1'b0;
    #1;
    chk(vmem[set] == (ef ? 1'b1 : vmem[set]), {req, " line"}, vmem[set], 1);
  endtask

  task automatic run_inv(input logic [31:0] d, input int lo, input int hi, input string req);
    int cnt;
    preset(1'b1);
    wr_cfg(d);
    count_busy(cnt);
    chk(cnt == hi - lo + 1, {req, " busy cycles"}, cnt, hi - lo + 1);
    for (int i = 0; i < SETS; i++) begin
      if (i >= lo && i <= hi) begin
        chk(clr_cnt[i] == 1 && vmem[i] == 1'b0, {req, " cleared set"}, clr_cnt[i], 1);
      end else begin
        chk(clr_cnt[i] == 0 && vmem[i] == 1'b1, {req, " kept set"}, clr_cnt[i], 0);
      end
    end
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(va_we == 1'b0, "R1 no write", va_we, 0);
    preset(1'b1);
    miss(5, 1'b1, 1'b1, "R1 freeze off");
  endtask

  task automatic t_full;
    run_inv(W_INV, 0, SETS - 1, "R2 R5 none");
    run_inv(W_INV | W_ISC | W_DSC, 0, SETS - 1, "R5 both");
  endtask

  task automatic t_halves;
    run_inv(W_INV | W_ISC, 0, HALF - 1, "R3");
    run_inv(W_INV | W_DSC, HALF, SETS - 1, "R4");
    run_inv(W_INV | W_DSC | 32'h3, HALF, SETS - 1, "R4 org11");
  endtask

  task automatic t_org;
    run_inv(W_INV | W_ISC | 32'h1, 0, SETS - 1, "R5 instr org");
    run_inv(W_INV | W_DSC | 32'h2, 0, SETS - 1, "R5 data org");
  endtask

  task automatic t_busy_block;
    int cnt;
    preset(1'b1);
    wr_cfg(W_INV);
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      miss_req = 1'b1; miss_set = 3;
      cfg_we = 1'b1; cfg_wdata = W_INV | W_FRZ;
      #1;
      if (cnt == 2) chk(miss_gnt == 1'b0, "R6 no grant", miss_gnt, 0);
      @(negedge clk);
    end
    cfg_we = 1'b0; cfg_wdata = '0; miss_req = 1'b0;
    chk(cnt == SETS, "R6 one sweep", cnt, SETS);
    @(negedge clk);
    chk(busy == 1'b0, "R6 write ignored", busy, 0);
    vmem[3] = 1'b1;
    miss(3, 1'b1, 1'b1, "R6 freeze unchanged");
  endtask

  task automatic t_miss;
    preset(1'b0);
    miss(7, 1'b1, 1'b1, "R7 invalid");
    chk(vmem[7] == 1'b1, "R7 refilled", vmem[7], 1);
    miss(7, 1'b1, 1'b1, "R7 valid");
  endtask

  task automatic t_freeze;
    wr_cfg(W_FRZ);
    preset(1'b0);
    vmem[2] = 1'b1;
    miss(2, 1'b1, 1'b0, "R8 valid frozen");
    chk(vmem[2] == 1'b1, "R8 kept", vmem[2], 1);
    miss(9, 1'b1, 1'b1, "R8 invalid filled");
    chk(vmem[9] == 1'b1, "R8 filled", vmem[9], 1);
    wr_cfg(32'h0);
  endtask

  task automatic t_frz_inv;
    run_inv(W_INV | W_FRZ, 0, SETS - 1, "R9 sweep");
    miss(4, 1'b1, 1'b1, "R9 cleared fill");
    miss(4, 1'b1, 1'b0, "R9 still frozen");
    wr_cfg(32'h0);
  endtask

  task automatic t_selfclear;
    int cnt;
    run_inv(W_INV, 0, SETS - 1, "R10 base");
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R10 self clear", busy, 0);
    preset(1'b1);
    wr_cfg(W_ISC);
    count_busy(cnt);
    chk(cnt == 0, "R10 no inv bit", cnt, 0);
    chk(clr_cnt[0] == 0, "R10 no clear", clr_cnt[0], 0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    miss_req = 1'b0; miss_set = '0;
    preset(1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_halves();
    t_org();
    t_busy_block();
    t_miss();
    t_freeze();
    t_frz_inv();
    t_selfclear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule